// File: doc/BRIEF.md
# Dual-Channel Double-Latched Converter Input Stage

This block is a cycle-level model of the digital input section of a two-channel, 14-bit current-steering converter. It runs on a fast system clock. Each channel's write strobe and update clock are sampled as ordinary signals, and their edges are found inside the block. Every channel holds two latches. A write-strobe rise captures the channel's data word into an input latch. The following write-strobe fall hands that word to a staging register. Only a later update-clock rise copies the staged word into the converter latch, which drives the output code. Tying the strobe and the update clock together is legal. In that case each rising edge presents the word written on the previous rising edge.

Per channel, the block drives the held code, its complement (full scale minus the code), an output-valid level and a one-cycle sequencing-error pulse. The error pulse fires when the write strobe rises one system clock before the update clock that should have come with it. A power-down input freezes both channels: they keep their codes, ignore their strobes and drop their valid levels. A gain-mode input lets channel 2 reuse channel 1's full-scale setting.

The outputs are held levels and have no back-pressure. The code is valid whenever `code_vld` is high, and a consumer samples it at any time. The strobes carry no ready signal, because a converter latch accepts every update-clock edge.

Top module: `twin_dac_ingress`

## Requirements
- R1: While `rst_n` is low, all input, staging and converter latches are cleared to code 0 and both error flags to 0. After reset, `code_out` reads 0 and `code_cmp` reads 16383 on both channels.
- R2: A write-strobe rise, seen on the edge where the sampled strobe is 1 and was 0 one clock earlier, loads that channel's data port into its input latch. Changes on the data port at any other time have no effect on the code that later appears.
- R3: A write-strobe fall moves the input latch into the staging register. The converter code changes only on an update-clock rise, and then takes the staged value from before that edge. This holds when the fall and the rise land on the same edge: the rise then takes the older staged value.
- R4: With the strobe and the update clock tied together, each rising edge makes `code_out` show the word captured at the previous rising edge.
- R5: Coding is straight binary, with bit 13 as the MSB. `code_cmp` always equals 16383 minus `code_out`, so code 16383 gives cmp 0, code 8192 gives cmp 8191, and code 0 gives cmp 16383.
- R6: `seq_err[ch]` is high for exactly one system clock, in the cycle after an update-clock rise. It fires when, one clock before that rise, a write-strobe rise was seen without an update-clock rise on the same edge. A simultaneous rise, an earlier update rise, or a gap of two or more clocks raises no flag.
- R7: While `pwr_down` is 1, `code_vld` is 0 on both channels, strobes and update clocks change no latch and raise no error, and the held codes stay visible. After release, the codes are unchanged.
- R8: With `gain_shared` at 0, each channel's `fs_eff` equals its own `fs_set`. With `gain_shared` at 1, both channels use channel 0's `fs_set`, and channel 1's `fs_set` has no effect.
- R9: The channels are independent: strobe activity on one channel never changes the other channel's code or error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_data | input | 2x14 | Per-channel data word, straight binary |
| ch_wrt | input | 2 | Per-channel write strobe |
| ch_upd | input | 2 | Per-channel update clock |
| pwr_down | input | 1 | 1 = power-down, 0 = normal operation |
| gain_shared | input | 1 | 1 = both channels use channel 0's full-scale setting |
| fs_set | input | 2x8 | Per-channel full-scale setting |
| code_out | output | 2x14 | Held converter code |
| code_cmp | output | 2x14 | Complementary code, 16383 minus code |
| code_vld | output | 2 | Output-valid level, low in power-down |
| seq_err | output | 2 | One-cycle sequencing-error pulse |
| fs_eff | output | 2x8 | Full-scale setting in effect per channel |

## Verification
The hand-over on a write-strobe fall and the converter update on an update-clock rise can fall on the same system-clock edge. A directed sequence holds the strobe high, then drops it on the very edge where the update clock rises. The bench expects the code to keep the older staged word on that edge and to take the new word only at the next update rise. Random stimulus, with strobes both tied and free-running, hits this collision many times. A bench model of the two latch stages judges each occurrence every cycle.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic {
    GAIN_PER_CH = 1'b0,
    GAIN_SHARED = 1'b1
  } gain_mode_e;
endpackage

// File: rtl/dac_edge_det.sv
module dac_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
  assign fall = ~sig & sig_q;
endmodule

// File: rtl/dac_chan_latch.sv
module dac_chan_latch #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd,
  input  logic [DATA_W-1:0] data,
  input  logic              wrt,
  input  logic              upd,
  output logic [DATA_W-1:0] code,
  output logic              seq_err
);
  logic w_rise, w_fall, u_rise, u_fall;
  logic [DATA_W-1:0] in_q, stage_q, conv_q;
  logic pend_q, err_q;

  dac_edge_det u_wrt_edge (.clk(clk), .rst_n(rst_n), .sig(wrt), .rise(w_rise), .fall(w_fall));
  dac_edge_det u_upd_edge (.clk(clk), .rst_n(rst_n), .sig(upd), .rise(u_rise), .fall(u_fall));

  // Two latch stages plus converter latch; all frozen while powered down.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '0;
      stage_q <= '0;
      conv_q  <= '0;
    end else if (!pd) begin
      if (w_rise) in_q    <= data;
      if (w_fall) stage_q <= in_q;
      if (u_rise) conv_q  <= stage_q;
    end
  end

  // Strobe rose without its update clock: flag if the update rises next cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= w_rise & ~u_rise & ~pd;
      err_q  <= pend_q & u_rise & ~pd;
    end
  end

  assign code    = conv_q;
  assign seq_err = err_q;

  AST_INLATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_rise && !pd) |=> $stable(in_q)); // R2
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_fall && !pd) |=> $stable(stage_q)); // R3
  AST_UPD_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    u_fall |=> $stable(conv_q)); // R3
  AST_PD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> $stable(conv_q) && $stable(in_q) && $stable(stage_q)); // R7
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err); // R6
endmodule

// File: rtl/dac_gain_sel.sv
module dac_gain_sel
  import dac_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int FS_W = 8
) (
  input  gain_mode_e                mode,
  input  logic [NCH-1:0][FS_W-1:0]  fs_set,
  output logic [NCH-1:0][FS_W-1:0]  fs_eff
);
  for (genvar i = 0; i < NCH; i++) begin : g_fs
    if (i == 0) begin : g_lead
      assign fs_eff[i] = fs_set[0];
    end else begin : g_follow
      assign fs_eff[i] = (mode == GAIN_SHARED) ? fs_set[0] : fs_set[i];
    end
  end
endmodule

// File: rtl/twin_dac_ingress.sv
module twin_dac_ingress
  import dac_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 14,
  parameter int FS_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0][DATA_W-1:0] ch_data,
  input  logic [NCH-1:0]            ch_wrt,
  input  logic [NCH-1:0]            ch_upd,
  input  logic                      pwr_down,
  input  logic                      gain_shared,
  input  logic [NCH-1:0][FS_W-1:0]  fs_set,
  output logic [NCH-1:0][DATA_W-1:0] code_out,
  output logic [NCH-1:0][DATA_W-1:0] code_cmp,
  output logic [NCH-1:0]            code_vld,
  output logic [NCH-1:0]            seq_err,
  output logic [NCH-1:0][FS_W-1:0]  fs_eff
);
  localparam logic [DATA_W-1:0] FULL_CODE = {DATA_W{1'b1}};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_chan_latch #(.DATA_W(DATA_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .pd      (pwr_down),
      .data    (ch_data[c]),
      .wrt     (ch_wrt[c]),
      .upd     (ch_upd[c]),
      .code    (code_out[c]),
      .seq_err (seq_err[c])
    );
    assign code_cmp[c] = FULL_CODE - code_out[c];
    assign code_vld[c] = ~pwr_down;

    AST_NO_ERR_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pwr_down) |-> !seq_err[c]); // R7
  end

  dac_gain_sel #(.NCH(NCH), .FS_W(FS_W)) u_gain (
    .mode   (gain_mode_e'(gain_shared)),
    .fs_set (fs_set),
    .fs_eff (fs_eff)
  );
endmodule

// File: tb/twin_dac_ingress_tb.sv
module twin_dac_ingress_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0][13:0] d = '0;
  logic [1:0] w = '0, u = '0;
  logic pd = 1'b0, gs = 1'b0;
  logic [1:0][7:0] fs = '0;
  logic [1:0][13:0] code_out, code_cmp;
  logic [1:0] code_vld, seq_err;
  logic [1:0][7:0] fs_eff;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_in[2], m_stage[2], m_conv[2], m_wq[2], m_uq[2], m_pend[2], m_err[2];

  always #5 clk = ~clk;

  twin_dac_ingress u_dut (
    .clk(clk), .rst_n(rst_n), .ch_data(d), .ch_wrt(w), .ch_upd(u),
    .pwr_down(pd), .gain_shared(gs), .fs_set(fs),
    .code_out(code_out), .code_cmp(code_cmp), .code_vld(code_vld),
    .seq_err(seq_err), .fs_eff(fs_eff)
  );

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_fs(int ch);
    if (ch == 1 && gs) return int'(fs[0]);
    return int'(fs[ch]);
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_in[c] = 0; m_stage[c] = 0; m_conv[c] = 0;
      m_wq[c] = 0; m_uq[c] = 0; m_pend[c] = 0; m_err[c] = 0;
    end
  endtask

  task automatic model_edge();
    for (int c = 0; c < 2; c++) begin
      bit wr, wf, ur;
      wr = w[c] && !m_wq[c];
      wf = !w[c] && m_wq[c];
      ur = u[c] && !m_uq[c];
      m_err[c]  = (m_pend[c] != 0 && ur && !pd) ? 1 : 0;
      m_pend[c] = (wr && !ur && !pd) ? 1 : 0;
      if (!pd) begin
        if (ur) m_conv[c]  = m_stage[c];
        if (wf) m_stage[c] = m_in[c];
        if (wr) m_in[c]    = int'(d[c]);
      end
      m_wq[c] = int'(w[c]);
      m_uq[c] = int'(u[c]);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < 2; c++) begin
      check_eq("R3 model code", int'(code_out[c]), m_conv[c]);
      check_eq("R5 model cmp", int'(code_cmp[c]), 16383 - m_conv[c]);
      check_eq("R6 model seq_err", int'(seq_err[c]), m_err[c]);
      check_eq("R7 model vld", int'(code_vld[c]), pd ? 0 : 1);
      check_eq("R8 model fs", int'(fs_eff[c]), exp_fs(c));
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
  endtask

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0d1a_c042));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++) begin
      check_eq("R1 reset code", int'(code_out[c]), 0);
      check_eq("R1 reset cmp", int'(code_cmp[c]), 16383);
      check_eq("R1 reset err", int'(seq_err[c]), 0);
    end
    rst_n = 1'b1;
    step();

    // R4/R5: tied strobe and update clock on channel 0
    d[0] = 14'd16383; w[0] = 1; u[0] = 1; step();
    w[0] = 0; u[0] = 0; step();
    d[0] = 14'd8192; w[0] = 1; u[0] = 1; step();
    check_eq("R4 tied shows previous word", int'(code_out[0]), 16383);
    check_eq("R5 cmp of full scale", int'(code_cmp[0]), 0);
    w[0] = 0; u[0] = 0; step();
    d[0] = 14'd0; w[0] = 1; u[0] = 1; step();
    check_eq("R4 tied second word", int'(code_out[0]), 8192);
    check_eq("R5 cmp of half scale", int'(code_cmp[0]), 8191);
    w[0] = 0; u[0] = 0; step();

    // R2/R3: channel 1, update rise before hand-over, data change ignored
    d[1] = 14'd100; w[1] = 1; step();
    d[1] = 14'd555; step();
    u[1] = 1; step();
    check_eq("R3 update before hand-over keeps old", int'(code_out[1]), 0);
    check_eq("R9 channel 0 untouched", int'(code_out[0]), 8192);
    u[1] = 0; step();
    // hand-over and update rise on the same edge
    w[1] = 0; u[1] = 1; step();
    check_eq("R3 same-edge fall and rise keeps old stage", int'(code_out[1]), 0);
    u[1] = 0; step();
    u[1] = 1; step();
    check_eq("R2 captured word only at strobe rise", int'(code_out[1]), 100);
    u[1] = 0; step();

    // R6: strobe rise one cycle ahead of update rise
    d[0] = 14'd77; w[0] = 1; step();
    u[0] = 1; step();
    check_eq("R6 error pulse", int'(seq_err[0]), 1);
    check_eq("R9 other channel no error", int'(seq_err[1]), 0);
    step();
    check_eq("R6 pulse lasts one cycle", int'(seq_err[0]), 0);
    w[0] = 0; u[0] = 0; step();
    // two-cycle gap: no flag
    w[0] = 1; step(); step();
    u[0] = 1; step();
    check_eq("R6 gap of two no flag", int'(seq_err[0]), 0);
    w[0] = 0; u[0] = 0; step();

    // R7: power-down freezes codes
    begin
      int held;
      held = int'(code_out[0]);
      pd = 1; d[0] = 14'd4321;
      for (int k = 0; k < 6; k++) begin
        w[0] = ~w[0]; u[0] = ~u[0]; step();
        check_eq("R7 code frozen in power-down", int'(code_out[0]), held);
        check_eq("R7 valid low", int'(code_vld[1]), 0);
      end
      w[0] = 0; u[0] = 0; step();
      pd = 0; step();
      check_eq("R7 code kept after release", int'(code_out[0]), held);
      check_eq("R7 valid back", int'(code_vld[0]), 1);
    end

    // R8: gain mode
    fs[0] = 8'd10; fs[1] = 8'd20; gs = 1; step();
    check_eq("R8 shared uses channel 0", int'(fs_eff[1]), 10);
    fs[1] = 8'd77; step();
    check_eq("R8 channel 1 setting ignored", int'(fs_eff[1]), 10);
    gs = 0; step();
    check_eq("R8 independent setting", int'(fs_eff[1]), 77);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < 2; c++) begin
        d[c] = 14'($urandom);
        if ($urandom_range(3) == 0) w[c] = ~w[c];
        if ($urandom_range(1) == 0) u[c] = w[c];
        else if ($urandom_range(3) == 0) u[c] = ~u[c];
        fs[c] = 8'($urandom);
      end
      pd = ($urandom_range(9) == 0);
      gs = 1'($urandom);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule